// File: doc/BRIEF.md
# Receive DMA Channel Sequencer

This block runs one receive DMA channel. Software fills a ring of buffer descriptors and sets the channel-enable control bit. The channel then reads the descriptor at the current ring index and checks it. It accepts bytes from a peripheral through a valid/ready handshake and writes each byte into the buffer that the descriptor points to. When the buffer is full, or the peripheral marks the end of a frame, the channel closes the descriptor. Closing means writing it back with the real byte count and the ready flag cleared, then moving on to the next ring slot.

Each way of ending a buffer latches its own sticky pending bit in a status word. The five ways are a normal close, an early close at end of frame, an error, a descriptor that is not ready, and an abort. A single interrupt line is the masked OR of those bits. An error or a not-ready descriptor parks the channel in a stopped state. Software recovers it by clearing the enable bit and then setting it again, and the channel restarts at a ring index chosen by software. Setting the abort control bit closes the open buffer and holds the channel idle until the abort bit drops while enable is high.

Descriptor word, most significant bit first: ready flag `f` (1 means the buffer belongs to the channel), interrupt flag `i`, wrap flag `w`, buffer pointer `ptr` (16 bits), buffer length `len` (12 bits), actual count `cnt` (12 bits).

Top module: `rxdma_chan`

## Requirements
- R1: When the byte count reaches `len`, the channel closes the buffer. It writes the descriptor back with `cnt` equal to `len` and `f` cleared, and sets the normal-close pending bit (status bit 31) if `i` is 1.
- R2: With `i` equal to 0, a normal or early close writes the descriptor back but sets neither status bit 31 nor status bit 27.
- R3: A byte flagged `rx_last` before `len` is reached closes the buffer early. The written-back `cnt` is the number of bytes taken. Status bit 27 is set if `i` is 1, and the channel goes on to the next descriptor. If the last byte also fills the buffer, the close counts as normal.
- R4: A fetched descriptor that has `f` set but has `len` equal to 0 or `ptr` equal to 0 sets the error bit (status bit 30). The channel then stops: it drops `busy`, does not assert `rx_ready`, and makes no writes.
- R5: A fetched descriptor with `f` equal to 0 sets the not-ready bit (status bit 29) and stops the channel in the same way.
- R6: A stopped channel stays stopped while `ctl_en` is high, even if the descriptor has since become valid. After `ctl_en` goes low and then high again, the channel fetches from the slot given by `ctl_start_idx`.
- R7: When `ctl_abort` is high during a transfer, the channel closes the open descriptor with the bytes taken so far and sets the abort bit (status bit 28). It stays idle until `ctl_abort` is low while `ctl_en` is high.
- R8: `stat_rdata` places the pending bits at 31 down to 27 in the order normal, error, not-ready, abort, early. It reads `rx_fifo_empty` at bit 0, `rx_fifo_full` at bit 1 and the busy flag at bit 2. All other bits read 0. Everything resets to 0, and the low three bits are not changed by writes.
- R9: A write with `stat_wr` clears each pending bit whose data bit is 1. Data bits of 0 have no effect. When a hardware set and a clear hit the same bit in the same cycle, the set wins.
- R10: `irq` is high exactly when some pending bit is set and its bit in `irq_mask` (bit 4 = normal ... bit 0 = early) is 1.
- R11: After a normal or early close the ring index advances by one modulo the ring size. If the closed descriptor has `w` set, the index goes to 0 instead.
- R12: Byte k of a buffer (counting from 0) is written to address `ptr + k`, and a byte is written only in a cycle where both `rx_valid` and `rx_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | 1 | Channel enable control bit |
| ctl_abort | input | 1 | Channel abort control bit |
| ctl_start_idx | input | IDX_W | Ring slot used when the channel starts |
| irq_mask | input | 5 | Per-pending-bit interrupt enables |
| stat_wr | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata | input | 32 | Status write data |
| stat_rdata | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| desc_addr | output | IDX_W | Descriptor memory slot (read and write) |
| desc_rdata | input | DESC_W | Descriptor read data, same-cycle |
| desc_we | output | 1 | Descriptor write-back strobe |
| desc_wdata | output | DESC_W | Descriptor write-back data |
| rx_valid | input | 1 | Peripheral byte valid |
| rx_data | input | 8 | Peripheral byte |
| rx_last | input | 1 | Byte ends a frame |
| rx_ready | output | 1 | Channel accepts a byte |
| rx_fifo_empty | input | 1 | Receive FIFO empty flag, reported |
| rx_fifo_full | input | 1 | Receive FIFO full flag, reported |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Data memory byte address |
| mem_wdata | output | 8 | Data memory write byte |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same cycle as a hardware set of that same bit. The bench sets this up from the stopped state. It drops `ctl_en`, raises it again toward a slot holding a descriptor with a null pointer, and counts two clock edges to the fetch cycle. It then pulses `stat_wr` to clear the error bit in exactly that cycle. Reaching the stopped state on purpose is also indirect: a wrap flag on the last filled slot sends the ring back to a descriptor that was already closed.

// File: rtl/rxdma_pkg.sv
// Package rxdma_pkg
// Shared widths, the descriptor layout, the sequencer states and the
// positions of the pending bits for the receive DMA channel.
// Assumes: one byte per transfer, descriptors read in a single cycle.
package rxdma_pkg;

    parameter int PTR_W  = 16;
    parameter int LEN_W  = 12;
    parameter int DATA_W = 8;
    parameter int NPEND  = 5;

    // Pending bit positions inside the 5-bit pending vector (MSB = status bit 31)
    localparam int PB_NORMAL = 4;
    localparam int PB_ERROR  = 3;
    localparam int PB_NRDY   = 2;
    localparam int PB_ABORT  = 1;
    localparam int PB_EARLY  = 0;

    typedef struct packed {
        logic             f;
        logic             i;
        logic             w;
        logic [PTR_W-1:0] ptr;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
    } rxdma_desc_t;

    localparam int DESC_W = $bits(rxdma_desc_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_CLOSE,
        ST_STOP
    } rxdma_state_t;

endpackage

// File: rtl/rxdma_desc_check.sv
// Module rxdma_desc_check
// Classifies a fetched descriptor: not owned by the channel, or owned but
// malformed (zero length or null buffer pointer).
// Assumes: purely combinational, evaluated in the fetch cycle.
module rxdma_desc_check
    import rxdma_pkg::*;
(
    input  logic             own_f,
    input  logic [PTR_W-1:0] buf_ptr,
    input  logic [LEN_W-1:0] buf_len,
    output logic             not_ready,
    output logic             malformed
);

    // Verdict on the descriptor fields
    always_comb begin
        not_ready = !own_f;
        malformed = (buf_len == '0) || (buf_ptr == '0);
    end

endmodule

// File: rtl/rxdma_pend_reg.sv
// Module rxdma_pend_reg
// Sticky pending bits with write-1-to-clear, where a hardware set wins
// over a clear in the same cycle, and the masked interrupt output.
// Assumes: at most a few set pulses per cycle, all synchronous.
module rxdma_pend_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic         sw_wr,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] pend,
    output logic         irq
);

    logic [N-1:0] clr_eff;

    // Clear only takes effect on a write strobe
    always_comb clr_eff = sw_wr ? sw_clr : '0;

    // Pending storage: clear first, then set
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_eff) | hw_set;
    end

    // Interrupt is any enabled pending bit
    always_comb irq = |(pend & mask);

endmodule

// File: rtl/rxdma_seq.sv
// Module rxdma_seq
// Channel sequencer: fetches and checks descriptors, moves peripheral
// bytes to memory, writes back closed descriptors and walks the ring.
// Assumes: descriptor memory returns data in the cycle it is addressed;
// the data memory accepts one byte write per cycle.
module rxdma_seq
    import rxdma_pkg::*;
#(
    parameter int RING_SIZE = 8,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              ctl_abort,
    input  logic [IDX_W-1:0]  start_idx,
    input  rxdma_desc_t       desc_rdata,
    input  logic              not_ready,
    input  logic              malformed,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic [IDX_W-1:0]  desc_addr,
    output logic              desc_we,
    output rxdma_desc_t       desc_wdata,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NPEND-1:0]  hw_set,
    output logic              busy,
    output logic              stopped
);

    rxdma_state_t      state;
    logic [IDX_W-1:0]  idx;
    rxdma_desc_t       cur;
    logic [LEN_W-1:0]  cnt;
    logic [NPEND-1:0]  close_vec;
    logic              close_idle;
    logic [LEN_W-1:0]  cnt_inc;
    logic [IDX_W-1:0]  idx_next;

    // Byte path and handshake
    always_comb begin
        rx_ready  = (state == ST_XFER) && !ctl_abort;
        mem_we    = rx_ready && rx_valid;
        mem_addr  = cur.ptr + PTR_W'(cnt);
        mem_wdata = rx_data;
        cnt_inc   = cnt + 1'b1;
    end

    // Descriptor port and ring index successor
    always_comb begin
        desc_addr      = idx;
        desc_we        = (state == ST_CLOSE);
        desc_wdata     = cur;
        desc_wdata.f   = 1'b0;
        desc_wdata.cnt = cnt;
        idx_next       = (cur.w || idx == IDX_W'(RING_SIZE - 1)) ? '0 : idx + 1'b1;
    end

    // Pending-bit set pulses for fetch verdicts and closures
    always_comb begin
        hw_set = '0;
        if (state == ST_FETCH) begin
            if (ctl_abort)      hw_set[PB_ABORT] = 1'b1;
            else if (not_ready) hw_set[PB_NRDY]  = 1'b1;
            else if (malformed) hw_set[PB_ERROR] = 1'b1;
        end else if (state == ST_CLOSE) begin
            hw_set = close_vec;
        end
    end

    // Channel activity flags
    always_comb begin
        busy    = (state == ST_FETCH) || (state == ST_XFER) || (state == ST_CLOSE);
        stopped = (state == ST_STOP);
    end

    // State, ring index, current descriptor and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            cur        <= '0;
            cnt        <= '0;
            close_vec  <= '0;
            close_idle <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ctl_en && !ctl_abort) begin
                        idx   <= start_idx;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (ctl_abort) begin
                        state <= ST_IDLE;
                    end else if (not_ready || malformed) begin
                        state <= ST_STOP;
                    end else begin
                        cur   <= desc_rdata;
                        cnt   <= '0;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (ctl_abort) begin
                        close_vec  <= NPEND'(1) << PB_ABORT;
                        close_idle <= 1'b1;
                        state      <= ST_CLOSE;
                    end else if (rx_valid) begin
                        cnt <= cnt_inc;
                        if (cnt_inc == cur.len) begin
                            close_vec  <= cur.i ? (NPEND'(1) << PB_NORMAL) : '0;
                            close_idle <= 1'b0;
                            state      <= ST_CLOSE;
                        end else if (rx_last) begin
                            close_vec  <= cur.i ? (NPEND'(1) << PB_EARLY) : '0;
                            close_idle <= 1'b0;
                            state      <= ST_CLOSE;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (close_idle) begin
                        state <= ST_IDLE;
                    end else begin
                        idx   <= idx_next;
                        state <= ST_FETCH;
                    end
                end
                ST_STOP: begin
                    if (!ctl_en) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxdma_chan.sv
// Module rxdma_chan
// Top of the receive DMA channel: descriptor checker, sequencer and the
// pending/interrupt register, plus assembly of the status word.
// Assumes: control bits are held by software registers outside the block.
module rxdma_chan
    import rxdma_pkg::*;
#(
    parameter int RING_SIZE = 8,
    localparam int IDX_W = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              ctl_abort,
    input  logic [IDX_W-1:0]  ctl_start_idx,
    input  logic [NPEND-1:0]  irq_mask,
    input  logic              stat_wr,
    input  logic [31:0]       stat_wdata,
    output logic [31:0]       stat_rdata,
    output logic              irq,
    output logic [IDX_W-1:0]  desc_addr,
    input  logic [DESC_W-1:0] desc_rdata,
    output logic              desc_we,
    output logic [DESC_W-1:0] desc_wdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    input  logic              rx_fifo_empty,
    input  logic              rx_fifo_full,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int PAD_W = 32 - NPEND - 3;

    rxdma_desc_t      rd_desc;
    rxdma_desc_t      wb_desc;
    logic             not_ready;
    logic             malformed;
    logic [NPEND-1:0] hw_set;
    logic [NPEND-1:0] pend;
    logic             busy_w;
    logic             stop_w;
    logic             unused_wdata_bits;

    // Type views of the descriptor buses
    always_comb begin
        rd_desc    = rxdma_desc_t'(desc_rdata);
        desc_wdata = wb_desc;
    end

    rxdma_desc_check u_check (
        .own_f     (rd_desc.f),
        .buf_ptr   (rd_desc.ptr),
        .buf_len   (rd_desc.len),
        .not_ready (not_ready),
        .malformed (malformed)
    );

    rxdma_seq #(.RING_SIZE(RING_SIZE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .ctl_abort  (ctl_abort),
        .start_idx  (ctl_start_idx),
        .desc_rdata (rd_desc),
        .not_ready  (not_ready),
        .malformed  (malformed),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_ready   (rx_ready),
        .desc_addr  (desc_addr),
        .desc_we    (desc_we),
        .desc_wdata (wb_desc),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .hw_set     (hw_set),
        .busy       (busy_w),
        .stopped    (stop_w)
    );

    rxdma_pend_reg #(.N(NPEND)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_wr  (stat_wr),
        .sw_clr (stat_wdata[31 -: NPEND]),
        .mask   (irq_mask),
        .pend   (pend),
        .irq    (irq)
    );

    // Status word: pending bits on top, live flags at the bottom
    always_comb begin
        stat_rdata        = {pend, {PAD_W{1'b0}}, busy_w, rx_fifo_full, rx_fifo_empty};
        unused_wdata_bits = ^stat_wdata[31-NPEND:0];
    end

endmodule

// File: rtl/rxdma_chan_chk.sv
// Module rxdma_chan_chk
// Property checker for rxdma_chan, attached with bind below.
// Assumes: reset is held low from time zero until the first edges pass.
module rxdma_chan_chk
    import rxdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              ctl_abort,
    input logic              stat_wr,
    input logic [31:0]       stat_rdata,
    input logic              irq,
    input logic              desc_we,
    input logic [DESC_W-1:0] desc_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              mem_we,
    input logic              stopped
);

    rxdma_desc_t wb;
    always_comb wb = rxdma_desc_t'(desc_wdata);

    // R1: a written-back descriptor is handed back to software
    a_r1_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> !wb.f);

    // R4: a stopped channel is silent
    a_r4_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!rx_ready && !mem_we && !desc_we && !stat_rdata[2]));

    // R6: leaving the stopped state needs enable low
    a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && ctl_en) |=> stopped);

    // R7: abort keeps an inactive channel inactive
    a_r7_abort_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_abort && !stat_rdata[2]) |=> !stat_rdata[2]);

    // R9: without a write no pending bit falls
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_rdata[31:27] & $past(stat_rdata[31:27])) == $past(stat_rdata[31:27])));

    // R10: interrupt only with something pending
    a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_rdata[31:27] != '0));

    // R12: memory writes only on a handshake
    a_r12_write_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rx_valid && rx_ready));

endmodule

bind rxdma_chan rxdma_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (ctl_en),
    .ctl_abort  (ctl_abort),
    .stat_wr    (stat_wr),
    .stat_rdata (stat_rdata),
    .irq        (irq),
    .desc_we    (desc_we),
    .desc_wdata (desc_wdata),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .mem_we     (mem_we),
    .stopped    (stop_w)
);

// File: tb/rxdma_chan_test.sv
// Bench rxdma_chan_test: table-driven ring walk, then directed tests for
// stop recovery, set-versus-clear, abort, masking and read-only flags.
module rxdma_chan_test;
    import rxdma_pkg::*;

    localparam int RING  = 8;
    localparam int IDX_W = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ctl_en, ctl_abort;
    logic [IDX_W-1:0]  ctl_start_idx;
    logic [NPEND-1:0]  irq_mask;
    logic              stat_wr;
    logic [31:0]       stat_wdata;
    logic [31:0]       stat_rdata;
    logic              irq;
    logic [IDX_W-1:0]  desc_addr;
    logic [DESC_W-1:0] desc_rdata;
    logic              desc_we;
    logic [DESC_W-1:0] desc_wdata;
    logic              rx_valid, rx_last, rx_ready;
    logic [7:0]        rx_data;
    logic              rx_fifo_empty, rx_fifo_full;
    logic              mem_we;
    logic [PTR_W-1:0]  mem_addr;
    logic [7:0]        mem_wdata;

    rxdma_desc_t dring [RING];
    logic [7:0]  dbuf  [256];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rxdma_chan #(.RING_SIZE(RING)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_abort(ctl_abort),
        .ctl_start_idx(ctl_start_idx), .irq_mask(irq_mask), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .irq(irq),
        .desc_addr(desc_addr), .desc_rdata(desc_rdata), .desc_we(desc_we),
        .desc_wdata(desc_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_ready(rx_ready), .rx_fifo_empty(rx_fifo_empty),
        .rx_fifo_full(rx_fifo_full), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    assign desc_rdata = dring[desc_addr];

    always @(posedge clk) begin
        if (desc_we) dring[desc_addr] <= rxdma_desc_t'(desc_wdata);
        if (mem_we)  dbuf[mem_addr[7:0]] <= mem_wdata;
    end

    typedef struct packed {
        int       len;
        int       n;
        bit       last;
        bit       ien;
        bit       wrap;
        bit [4:0] pend;
        bit       busy;
    } vec_t;

    // Ring walk: normal, early, last-on-full, no-interrupt with wrap into a closed slot
    localparam vec_t VEC [4] = '{
        '{len: 4, n: 4, last: 1'b0, ien: 1'b1, wrap: 1'b0, pend: 5'b10000, busy: 1'b1},
        '{len: 6, n: 3, last: 1'b1, ien: 1'b1, wrap: 1'b0, pend: 5'b00001, busy: 1'b1},
        '{len: 3, n: 3, last: 1'b1, ien: 1'b1, wrap: 1'b0, pend: 5'b10000, busy: 1'b1},
        '{len: 5, n: 5, last: 1'b0, ien: 1'b0, wrap: 1'b1, pend: 5'b00100, busy: 1'b0}
    };

    function automatic rxdma_desc_t mk(input bit f, input bit i, input bit w,
                                       input int ptr, input int len);
        rxdma_desc_t d;
        d.f = f; d.i = i; d.w = w;
        d.ptr = PTR_W'(ptr); d.len = LEN_W'(len); d.cnt = '0;
        return d;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic w1c(input logic [31:0] d);
        stat_wr = 1'b1; stat_wdata = d;
        @(negedge clk);
        stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic send(input int n, input bit last, input int base);
        for (int b = 0; b < n; b++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(base + b);
            rx_last  = last && (b == n - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic toggle_en();
        ctl_en = 1'b0;
        @(negedge clk);
        ctl_en = 1'b1;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_en = 1'b0; ctl_abort = 1'b0; ctl_start_idx = '0;
        irq_mask = 5'h1F; stat_wr = 1'b0; stat_wdata = '0;
        rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
        rx_fifo_empty = 1'b1; rx_fifo_full = 1'b0;
        for (int k = 0; k < RING; k++) dring[k] = '0;
        for (int k = 0; k < 256; k++) dbuf[k] = '0;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state, empty flag at bit 0
        chk("R8 reset status", 64'(stat_rdata), 64'h1);
        chk("R10 reset irq", 64'(irq), 64'h0);
        chk("R4 reset ready", 64'(rx_ready), 64'h0);

        for (int k = 0; k < 4; k++)
            dring[k] = mk(1'b1, VEC[k].ien, VEC[k].wrap, 16'h10 + 16'h20 * k, VEC[k].len);
        dring[4] = mk(1'b1, 1'b0, 1'b0, 16'hF0, 8);
        ctl_en = 1'b1;

        for (int k = 0; k < 4; k++) begin
            logic ok;
            send(VEC[k].n, VEC[k].last, k * 16);
            wait_n(4);
            // R1 R3 R2: write-back with count and F cleared
            chk($sformatf("R1 R3 writeback row %0d", k),
                64'({dring[k].f, dring[k].cnt}), 64'({1'b0, LEN_W'(VEC[k].n)}));
            ok = 1'b1;
            for (int b = 0; b < VEC[k].n; b++)
                if (dbuf[8'(16'h10 + 16'h20 * k + b)] !== 8'(k * 16 + b)) ok = 1'b0;
            chk($sformatf("R12 data row %0d", k), 64'(ok), 64'h1);
            // R2 R5 R11: pending bits after the close (row 3 wraps to a closed slot)
            chk($sformatf("R2 R5 R11 pending row %0d", k), 64'(stat_rdata[31:27]), 64'(VEC[k].pend));
            chk($sformatf("R10 irq row %0d", k), 64'(irq), 64'(VEC[k].pend != 0));
            chk($sformatf("R11 busy row %0d", k), 64'(stat_rdata[2]), 64'(VEC[k].busy));
            w1c(32'hF800_0000);
        end

        // R6: stopped channel ignores a now-valid descriptor while enabled
        dring[0] = mk(1'b1, 1'b0, 1'b0, 16'h10, 4);
        wait_n(3);
        chk("R6 stays stopped", 64'({stat_rdata[2], rx_ready}), 64'h0);

        dring[5] = mk(1'b1, 1'b0, 1'b0, 16'hA0, 8);
        dring[6] = mk(1'b1, 1'b1, 1'b0, 16'h00, 4);
        ctl_start_idx = 3'd5;
        toggle_en();
        wait_n(3);
        chk("R6 restart slot", 64'({stat_rdata[2], rx_ready, desc_addr}), 64'({2'b11, 3'd5}));
        send(2, 1'b1, 8'h60);
        wait_n(4);
        chk("R3 early close no-irq", 64'({dring[5].f, dring[5].cnt}), 64'({1'b0, LEN_W'(2)}));
        chk("R4 null pointer error", 64'(stat_rdata[31:27]), 64'b01000);
        chk("R4 stopped after error", 64'(stat_rdata[2]), 64'h0);

        // R9: zero writes and writes to clear bits have no effect
        w1c(32'h0);
        chk("R9 write zero", 64'(stat_rdata[31:27]), 64'b01000);
        w1c(32'h8000_0000);
        chk("R9 clear other bit", 64'(stat_rdata[31:27]), 64'b01000);
        w1c(32'h4000_0000);
        chk("R9 clear error", 64'(stat_rdata[31:27]), 64'b00000);

        // R9: set and clear in the same cycle, set wins
        ctl_start_idx = 3'd6;
        toggle_en();
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = 32'h4000_0000;
        @(negedge clk);
        stat_wr = 1'b0; stat_wdata = '0;
        chk("R9 set beats clear", 64'(stat_rdata[31:27]), 64'b01000);
        w1c(32'h4000_0000);

        // R7: abort mid-buffer
        dring[6] = mk(1'b1, 1'b1, 1'b0, 16'hC0, 10);
        toggle_en();
        wait_n(3);
        send(3, 1'b0, 8'h90);
        ctl_abort = 1'b1;
        wait_n(4);
        chk("R7 abort writeback", 64'({dring[6].f, dring[6].cnt}), 64'({1'b0, LEN_W'(3)}));
        chk("R7 abort pending", 64'(stat_rdata[31:27]), 64'b00010);
        chk("R12 abort data", 64'({dbuf[8'hC0], dbuf[8'hC1], dbuf[8'hC2]}), 64'h909192);
        dring[1] = mk(1'b1, 1'b0, 1'b0, 16'h30, 4);
        ctl_start_idx = 3'd1;
        wait_n(4);
        chk("R7 held idle", 64'({stat_rdata[2], rx_ready}), 64'h0);
        ctl_abort = 1'b0;
        wait_n(3);
        chk("R7 resumes", 64'({stat_rdata[2], desc_addr}), 64'({1'b1, 3'd1}));

        // R10: masking
        irq_mask = 5'b11101;
        @(negedge clk);
        chk("R10 masked", 64'(irq), 64'h0);
        irq_mask = 5'b00010;
        @(negedge clk);
        chk("R10 unmasked", 64'(irq), 64'h1);
        irq_mask = 5'h1F;

        // R8: read-only flags survive writes
        rx_fifo_full = 1'b1; rx_fifo_empty = 1'b0;
        w1c(32'h07FF_FFFF);
        chk("R8 readonly flags", 64'(stat_rdata), 64'h1000_0006);
        w1c(32'hFFFF_FFFF);
        chk("R8 after clear", 64'(stat_rdata), 64'h0000_0006);
        chk("R10 irq cleared", 64'(irq), 64'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule